// File: doc/BRIEF.md
# Carry-Save Distributed-Arithmetic FIR Engine

This block computes one output of a finite impulse response filter per input word. It does so bit-serially and uses no multipliers. The taps are split into six groups. For each group, the current bit of every tap word forms an address into a small constant table. Each table entry holds the sum of the group coefficients whose address bit is set.

The six table words go into a carry-save compressor each bit cycle, least significant bit first, with each word weighted by its bit position. The running total stays in redundant form as a partial-sum register and a partial-carry register, and both are fed back into the same compressor. The input word's sign bit is handled by taking the bitwise complement of the weighted table words. A single constant equal to the group count is added at the same time to supply the missing increments.

When the last bit cycle ends, the compressor result is captured into a second register pair, which acts as the once-per-sample strobe. The accumulators are then cleared. A single carry-propagate adder resolves the captured pair into the output word. Samples enter through a valid/ready port. An input is accepted only on a cycle where both `in_valid` and `in_ready` are high; `in_ready` stays low while a sample is in flight or a captured result is waiting. Results leave through a valid/ready port. A result is held unchanged until `out_ready` takes it, and back-pressure on the output stalls input acceptance once the capture pair is full.

Top module: `dafir_top`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and every tap word is zero.
- R2: A sample is taken only on a rising edge where `in_valid` and `in_ready` are both 1. In the cycle after that edge, `in_ready` is 0. It stays 0 for the WORD_W bit cycles and for as long as a captured result cannot move to the output.
- R3: When the output slot is free, `out_valid` rises on the (WORD_W+1)-th rising edge after the accepting edge. The capture of the redundant pair (the sample strobe) happens only at the end of the last bit cycle.
- R4: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` does not change. A result is consumed on an edge where both are 1.
- R5: `out_data` equals the sum over k of coef[k]·x[n−k], where tap 0 is the newest word, inputs and coefficients are two's complement, taps are zero before the first sample, and the result is exact in ACC_W bits.
- R6: Each bit cycle, the compressor reduces its NUM_SUB+3 operands (table words, partial sum, partial carry, correction) to a sum/carry pair. The pair has the same total modulo 2^ACC_W.
- R7: On the sign-bit cycle, the weighted table words enter the compressor complemented, and one correction constant equal to NUM_SUB (binary 0110 for six groups) is added. This makes the most negative input (−2^(WORD_W−1)) and any mix of signs exact.
- R8: After each capture, both accumulator registers start the next sample at zero, so back-to-back samples do not affect each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Engine can take a word |
| in_data | input | WORD_W | Two's complement input sample |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | ACC_W | Two's complement filter output |

## Verification
Several properties are checked on every cycle:
- The compressor output pair keeps the modulo total of its operands, including the complemented words and the correction on the sign cycle.
- `in_ready` falls after every acceptance.
- The capture happens only at the last bit.
- The accumulators are zero when a sample starts.
- The output is held under back-pressure.

Only the bench's scenarios can show that the numeric result is the true convolution. These scenarios are impulse responses, runs of the most negative and most positive words, back-to-back streams, and random data with a stalling consumer. The same holds for the exact cycle on which the result appears.

// File: rtl/dafir_pkg.sv
package dafir_pkg;
  // Width of the address into one group table: one bit per tap of the group.
  function automatic int addr_bits(int taps_per_sub);
    return taps_per_sub;
  endfunction

  // Bits needed to hold the sum of n signed values of width w.
  function automatic int sum_width(int w, int n);
    return (n <= 1) ? w : w + $clog2(n);
  endfunction
endpackage

// File: rtl/dafir_rom.sv
module dafir_rom #(
  parameter int TPS = 4,
  parameter int CW  = 8,
  parameter int RW  = 10,
  parameter logic [TPS*CW-1:0] COEF_SLICE = '0
) (
  input  logic [TPS-1:0]   addr,
  output logic [RW-1:0]    word
);
  localparam int DEPTH = 2**TPS;

  function automatic logic [RW-1:0] entry(int a);
    logic [RW-1:0] acc;
    logic [CW-1:0] c;
    acc = '0;
    for (int t = 0; t < TPS; t++) begin
      c = COEF_SLICE[t*CW +: CW];
      if (a[t]) acc = acc + {{(RW-CW){c[CW-1]}}, c};
    end
    return acc;
  endfunction

  logic [RW-1:0] table_w [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : g_entry
    assign table_w[a] = entry(a);
  end

  assign word = table_w[addr];
endmodule

// File: rtl/dafir_csa_tree.sv
module dafir_csa_tree #(
  parameter int N = 9,
  parameter int A = 21
) (
  input  logic [A-1:0] ops [N],
  output logic [A-1:0] sum_o,
  output logic [A-1:0] car_o
);
  logic [A-1:0] ss [N-1];
  logic [A-1:0] cc [N-1];

  assign ss[0] = ops[0];
  assign cc[0] = ops[1];

  for (genvar i = 1; i < N-1; i++) begin : g_stage
    logic [A-1:0] maj;
    assign ss[i] = ss[i-1] ^ cc[i-1] ^ ops[i+1];
    assign maj   = (ss[i-1] & cc[i-1]) | (ss[i-1] & ops[i+1]) | (cc[i-1] & ops[i+1]);
    assign cc[i] = {maj[A-2:0], 1'b0};
  end

  assign sum_o = ss[N-2];
  assign car_o = cc[N-2];

  // R6: redundant pair keeps the modulo total of all operands
  logic [A-1:0] ref_total;
  always_comb begin
    ref_total = '0;
    for (int i = 0; i < N; i++) ref_total = ref_total + ops[i];
    assert_tree_sum_R6: assert (ref_total == A'(sum_o + car_o))
      else $error("compressor total mismatch");
  end
endmodule

// File: rtl/dafir_ctrl.sv
module dafir_ctrl #(
  parameter int W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 cap_full,
  output logic                 in_ready,
  output logic                 accept,
  output logic                 busy,
  output logic [$clog2(W)-1:0] bit_idx,
  output logic                 last_bit
);
  localparam int CNT_W = $clog2(W);

  assign in_ready = !busy && !cap_full;
  assign accept   = in_valid && in_ready;
  assign last_bit = busy && (bit_idx == CNT_W'(W-1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      bit_idx <= '0;
    end else if (accept) begin
      busy    <= 1'b1;
      bit_idx <= '0;
    end else if (busy) begin
      if (last_bit) busy <= 1'b0;
      else          bit_idx <= bit_idx + 1'b1;
    end
  end
endmodule

// File: rtl/dafir_top.sv
module dafir_top #(
  parameter int WORD_W  = 8,
  parameter int COEF_W  = 8,
  parameter int NUM_SUB = 6,
  parameter int TPS     = 4,
  parameter logic [NUM_SUB*TPS*COEF_W-1:0] COEFS =
    192'h807F13E5229C04FB610AD73845B20FC17A06992CF0115EA3,
  parameter int ACC_W   = WORD_W + COEF_W + $clog2(NUM_SUB*TPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ACC_W-1:0]  out_data
);
  localparam int NT    = NUM_SUB * TPS;
  localparam int RW    = dafir_pkg::sum_width(COEF_W, TPS);
  localparam int AB    = dafir_pkg::addr_bits(TPS);
  localparam int NOPS  = NUM_SUB + 3;
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [ACC_W-1:0] CORR = ACC_W'(NUM_SUB);

  logic              accept, busy, last_bit, cap_vld;
  logic [CNT_W-1:0]  bit_idx;
  logic [WORD_W-1:0] taps [NT];
  logic [ACC_W-1:0]  acc_s, acc_c, cap_s, cap_c, tree_s, tree_c;
  logic [ACC_W-1:0]  ops [NOPS];
  logic [RW-1:0]     rom_w [NUM_SUB];

  dafir_ctrl #(.W(WORD_W)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cap_full(cap_vld),
    .in_ready(in_ready), .accept(accept), .busy(busy),
    .bit_idx(bit_idx), .last_bit(last_bit)
  );

  // Delay line: shift on accept, rotate one bit per cycle while busy
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NT; k++) taps[k] <= '0;
    end else if (accept) begin
      taps[0] <= in_data;
      for (int k = 1; k < NT; k++) taps[k] <= taps[k-1];
    end else if (busy) begin
      for (int k = 0; k < NT; k++) taps[k] <= {taps[k][0], taps[k][WORD_W-1:1]};
    end
  end

  for (genvar s = 0; s < NUM_SUB; s++) begin : g_sub
    logic [AB-1:0]    addr;
    logic [ACC_W-1:0] ext, weighted;
    for (genvar t = 0; t < TPS; t++) begin : g_bit
      assign addr[t] = taps[s*TPS+t][0];
    end
    dafir_rom #(.TPS(TPS), .CW(COEF_W), .RW(RW),
                .COEF_SLICE(COEFS[s*TPS*COEF_W +: TPS*COEF_W])) i_rom (
      .addr(addr), .word(rom_w[s])
    );
    assign ext      = {{(ACC_W-RW){rom_w[s][RW-1]}}, rom_w[s]};
    assign weighted = ext << bit_idx;
    assign ops[s]   = last_bit ? ~weighted : weighted;
  end

  assign ops[NUM_SUB]   = acc_s;
  assign ops[NUM_SUB+1] = acc_c;
  assign ops[NUM_SUB+2] = last_bit ? CORR : '0;

  dafir_csa_tree #(.N(NOPS), .A(ACC_W)) i_tree (
    .ops(ops), .sum_o(tree_s), .car_o(tree_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_s <= '0; acc_c <= '0;
      cap_s <= '0; cap_c <= '0; cap_vld <= 1'b0;
      out_valid <= 1'b0; out_data <= '0;
    end else begin
      if (cap_vld && (!out_valid || out_ready)) begin
        out_data  <= cap_s + cap_c;
        out_valid <= 1'b1;
        cap_vld   <= 1'b0;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
      if (last_bit) begin
        cap_s <= tree_s; cap_c <= tree_c; cap_vld <= 1'b1;
        acc_s <= '0;     acc_c <= '0;
      end else if (busy) begin
        acc_s <= tree_s; acc_c <= tree_c;
      end
    end
  end

  assert_ready_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  assert_capture_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_vld) |-> $past(last_bit));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_acc_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bit_idx == '0) |-> (acc_s == '0 && acc_c == '0));
endmodule

// File: tb/test_dafir_top.sv
module test_dafir_top;
  localparam int W     = 8;
  localparam int CW    = 8;
  localparam int NSUB  = 6;
  localparam int TPS   = 4;
  localparam int NT    = NSUB * TPS;
  localparam int A     = W + CW + $clog2(NT);

  function automatic logic [NT*CW-1:0] mk_coefs();
    logic [NT*CW-1:0] v;
    for (int k = 0; k < NT; k++) v[k*CW +: CW] = CW'((k*53 + 17) % 256);
    v[0 +: CW] = 8'h80;
    v[(NT-1)*CW +: CW] = 8'h7F;
    return v;
  endfunction
  localparam logic [NT*CW-1:0] CV = mk_coefs();

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 1;
  logic [W-1:0] in_data = '0;
  logic in_ready, out_valid;
  logic [A-1:0] out_data;

  always #2 clk = ~clk;

  dafir_top #(.WORD_W(W), .COEF_W(CW), .NUM_SUB(NSUB), .TPS(TPS), .COEFS(CV)) i_dafir_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  int checks = 0, errors = 0;
  string phase = "R5";
  bit stall_mode = 0;
  bit done = 0;
  int unsigned lcg = 32'h1234_5678;

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Behavioural reference model, updated on each rising edge
  int hist [NT];
  int coef [NT];
  bit m_busy = 0, m_capv = 0, m_outv = 0, m_fire = 0;
  int m_cnt = 0;
  logic [A-1:0] m_pend, m_cap, m_out;

  initial for (int k = 0; k < NT; k++) begin
    hist[k] = 0;
    coef[k] = int'($signed(CV[k*CW +: CW]));
  end

  always @(posedge clk) begin
    bit ready_now, free_now;
    longint acc;
    if (!rst_n) begin
      m_busy = 0; m_capv = 0; m_outv = 0; m_fire = 0; m_cnt = 0;
    end else begin
      ready_now = !m_busy && !m_capv;
      free_now  = !m_outv || out_ready;
      m_fire    = in_valid && ready_now;
      if (m_capv && free_now) begin
        m_out = m_cap; m_outv = 1; m_capv = 0;
      end else if (out_ready) m_outv = 0;
      if (m_busy) begin
        if (m_cnt == W-1) begin
          m_busy = 0; m_capv = 1; m_cap = m_pend;
        end else m_cnt++;
      end
      if (m_fire) begin
        for (int k = NT-1; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = int'($signed(in_data));
        acc = 0;
        for (int k = 0; k < NT; k++) acc += longint'(coef[k]) * hist[k];
        m_pend = A'(acc);
        m_busy = 1; m_cnt = 0;
      end
    end
  end

  // Compare on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(in_ready == (!m_busy && !m_capv), "R2", in_ready, !m_busy && !m_capv);
      check(out_valid == m_outv, "R3", out_valid, m_outv);
      if (m_outv)
        check(out_data == m_out, phase, $signed(out_data), $signed(m_out));
    end
  end

  // Consumer
  always @(negedge clk) begin
    lcg = lcg * 1103515245 + 12345;
    out_ready <= stall_mode ? lcg[17] : 1'b1;
  end

  task automatic send(logic [W-1:0] v, int gap);
    @(negedge clk);
    in_valid = 1; in_data = v;
    do begin
      @(posedge clk); #1;
    end while (!m_fire);
    @(negedge clk);
    in_valid = 0;
    for (int g = 0; g < gap; g++) @(negedge clk);
  endtask

  task automatic drain();
    for (int i = 0; i < 4*W + 8; i++) @(negedge clk);
  endtask

  // Watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(out_valid == 0, "R1", out_valid, 0);
    check(in_ready == 1, "R1", in_ready, 1);
    rst_n = 1;
    @(negedge clk);
    check(in_ready == 1, "R1", in_ready, 1);

    // R5: impulse response through zeroed taps
    phase = "R5";
    send(8'd1, 2);
    for (int i = 0; i < NT; i++) send(8'd0, 1);
    drain();

    // R7: extreme words exercise the sign-bit cycle
    phase = "R7";
    for (int i = 0; i < NT + 2; i++) send(8'h80, 0);
    for (int i = 0; i < 6; i++) send(8'h7F, 0);
    for (int i = 0; i < 8; i++) send((i % 2) ? 8'h80 : 8'h7F, 0);
    drain();

    // R8: back-to-back stream, accumulators must restart at zero
    phase = "R8";
    for (int i = 0; i < 30; i++) send(W'(i * 37 + 5), 0);
    drain();

    // R4 / R6: random data under a stalling consumer
    phase = "R4";
    stall_mode = 1;
    for (int i = 0; i < 40; i++) begin
      lcg = lcg * 1664525 + 1013904223;
      send(lcg[23:16], lcg[3:2]);
    end
    drain();
    stall_mode = 0;
    phase = "R6";
    for (int i = 0; i < 30; i++) begin
      lcg = lcg * 1664525 + 1013904223;
      send(lcg[15:8], 0);
    end
    drain();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule